// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block is the receive-side holding queue of a UART. A serial receiver pushes each assembled character together with three error flags (parity, framing, break). A host pops characters from the head. The block keeps all of these flags in the queue and builds a line-status byte from them. That byte shows the flags that belong to the character now at the head of the queue. It also shows a summary error bit, which stays high as long as any stored character carries an error.

An internal counter tracks how many stored entries are errored. Because of this counter, the summary bit falls only after the last errored character has left the queue. Intermediate clean reads do not clear it. The block also reports the fill level and a data-ready indication. An overrun flag latches when the receiver offers a character while the queue is full. That character is dropped. The host clears the overrun flag by strobing a status-read input.

Top module: `rx_err_fifo`

## Requirements
- R1: Characters are returned in write order. The queue holds up to DEPTH entries, with a default of 64. `rd_data` always presents the head character while the queue is non-empty.
- R2: `level` equals the number of stored characters. Status bit 0 (data ready) is 1 exactly when `level` is nonzero.
- R3: Status bit 4 is break, bit 3 is framing and bit 2 is parity. Each shows the flag stored with the current head character. A pop moves these bits to the next character's flags. All three read 0 when the queue is empty.
- R4: Status bit 7 is 1 while at least one stored character has any of its three flags set. It is 0 otherwise.
- R5: Status bit 1 (overrun) is set in the cycle after a write arrives while `level` equals DEPTH. That character is discarded, even if a read happens in the same cycle. The bit clears in the cycle after `lsr_rd` is high. If a new overrun occurs in the same cycle as `lsr_rd`, the set wins.
- R6: A read while the queue is empty is ignored. The level stays at zero, and a write in the same cycle is still accepted.
- R7: A write and a read in the same cycle on a non-empty, non-full queue leave `level` unchanged. The error summary accounts for both the incoming and the outgoing character.
- R8: After reset, `level` is 0 and the status byte reads 0x60.
- R9: Status bits 6 and 5 always read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver offers a character |
| wr_data | input | DW | Character from the receiver |
| wr_par | input | 1 | Parity error flag of the offered character |
| wr_frm | input | 1 | Framing error flag of the offered character |
| wr_brk | input | 1 | Break flag of the offered character |
| rd_en | input | 1 | Host pops the head character |
| lsr_rd | input | 1 | Host reads status; clears overrun |
| rd_data | output | DW | Head character |
| level | output | $clog2(DEPTH)+1 | Number of stored characters |
| lsr | output | 8 | Line-status byte |

## Verification
The assertions assume that the inputs are sampled cleanly at the rising edge. They accept every combination of `wr_en`, `rd_en` and `lsr_rd` in any cycle, including a read on an empty queue and a write on a full one. The only other assumption is that reset is applied before any traffic. The stimulus changes all inputs only at falling edges. It runs through phases weighted toward filling, draining, balanced traffic, error-heavy traffic and clean traffic. This mix keeps the queue repeatedly at both boundaries and makes the error summary rise and fall many times.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       wr_par,
  input  logic                       wr_frm,
  input  logic                       wr_brk,
  input  logic                       rd_en,
  input  logic                       lsr_rd,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic [7:0]                 lsr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, ecnt;
  logic          ovr;

  wire full     = (cnt == CW'(DEPTH));
  wire empty    = (cnt == '0);
  wire push     = wr_en && !full;
  wire pop      = rd_en && !empty;
  wire in_err   = wr_par | wr_frm | wr_brk;
  wire [EW-1:0] head = mem[rp];
  wire head_err = |head[EW-1:DW];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wp] <= {wr_brk, wr_frm, wr_par, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ecnt <= '0;
      ovr  <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt  <= cnt + CW'(push) - CW'(pop);
      ecnt <= ecnt + CW'(push && in_err) - CW'(pop && head_err);
      if (wr_en && full) ovr <= 1'b1;
      else if (lsr_rd)   ovr <= 1'b0;
    end
  end

  assign rd_data = head[DW-1:0];
  assign level   = cnt;
  assign lsr     = {ecnt != '0, 2'b11, empty ? 3'b000 : head[EW-1:DW], ovr, !empty};

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[0] == (level != '0));
  a_r4_err_le_level: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= cnt);
  a_r4_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[7] |-> lsr[0]);
  a_r3_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> lsr[4:2] == 3'b000);
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && level == CW'(DEPTH)) |=> lsr[1]);
  a_r5_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !(wr_en && level == CW'(DEPTH))) |=> !lsr[1]);
  a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH) && !rd_en) |=> level == CW'(DEPTH));
  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !wr_en) |=> level == '0);
  a_r7_same_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && level != '0 && level != CW'(DEPTH)) |=> $stable(level));
  a_r9_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6:5] == 2'b11);
endmodule

// File: tb/sim_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_rx_err_fifo;
  localparam int D = 8;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_par = 0, wr_frm = 0, wr_brk = 0, rd_en = 0, lsr_rd = 0;
  logic [7:0] wr_data = 0, rd_data, lsr;
  logic [3:0] level;
  int checks = 0, fails = 0;
  bit done = 0;
  bit [10:0] q[$];
  bit movr = 0;

  always #2.5 clk = ~clk;

  rx_err_fifo #(.DEPTH(D), .DW(8)) u0 (
    .clk, .rst_n, .wr_en, .wr_data, .wr_par, .wr_frm, .wr_brk,
    .rd_en, .lsr_rd, .rd_data, .level, .lsr);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int errs = 0;
    foreach (q[i]) if (q[i][10:8] != 0) errs++;
    chk("R2 level", level, q.size());
    chk("R2 ready", lsr[0], q.size() != 0);
    chk("R5 overrun", lsr[1], movr);
    chk("R3 head flags", lsr[4:2], q.size() ? q[0][10:8] : 0);
    chk("R4 summary", lsr[7], errs != 0);
    chk("R9 fixed", lsr[6:5], 3);
    if (q.size()) chk("R1 head data", rd_data, q[0][7:0]);
  endtask

  task automatic step(bit w, bit [7:0] d, bit [2:0] f, bit r, bit lr);
    bit full = (q.size() == D);
    wr_en = w; wr_data = d; wr_brk = f[2]; wr_frm = f[1]; wr_par = f[0];
    rd_en = r; lsr_rd = lr;
    if (w && full) movr = 1;
    else if (lr) movr = 0;
    if (r && q.size()) void'(q.pop_front());
    if (w && !full) q.push_back({f, d});
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset level", level, 0);
    chk("R8 reset lsr", lsr, 8'h60);
    rst_n = 1;
    @(negedge clk);
    chk("R8 lsr after release", lsr, 8'h60);
    // R6: read on empty, then read together with write on empty
    step(0, 0, 0, 1, 0);
    step(1, 8'hA5, 3'b010, 1, 0);
    // R5: fill past full, with a read in the overflowing cycle
    for (int i = 0; i < D + 2; i++) step(1, 8'(i), 3'(i), 0, 0);
    step(1, 8'h77, 0, 1, 0);
    step(1, 8'h78, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    // R4/R7: drain with concurrent writes, then drain fully
    for (int i = 0; i < 3 * D; i++) step(1, 8'(i + 40), (i % 4 == 0) ? 3'b001 : 3'b000, 1, 0);
    for (int i = 0; i < D + 2; i++) step(0, 0, 0, 1, 0);
    // phased sweeps: fill, drain, balanced, error-heavy, clean
    for (int ph = 0; ph < 5; ph++) begin
      int pw = (ph == 0) ? 80 : (ph == 1) ? 25 : 55;
      int pr = (ph == 0) ? 25 : (ph == 1) ? 80 : 50;
      int pe = (ph == 3) ? 70 : (ph == 4) ? 0 : 20;
      for (int c = 0; c < 3000; c++) begin
        bit [2:0] f = ($urandom % 100 < pe) ? 3'($urandom) : 3'b000;
        step($urandom % 100 < pw, 8'($urandom), f,
             $urandom % 100 < pr, $urandom % 100 < 10);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule